// File: doc/BRIEF.md
# Region-Timed Store Sequencer

This block sits between a small processor core and an external memory or peripheral bus, and it controls how each store reaches the bus. When the core presents a store request, the sequencer captures the data address, the write data and the access size. It turns the size and the low address bits into byte-lane enables. It then runs a write sequence on the bus and holds the core with a pause signal until the sequence ends.

The length of the sequence depends on the top address bit. The high region (top bit set) is taken to be slow asynchronous memory or peripherals. It gets one setup cycle before the write strobe and one hold cycle after it, so the address and data stay steady around the strobe. The low region is taken to be clocked memory, and the strobe fires in the cycle right after the request. In every cycle that belongs to no store, the address bus carries the program counter for instruction fetch, and the write-data bus is released.

Top module: `store_seq`

## Requirements
- R1: A store to an address with bit 31 set lasts four cycles: the request cycle, then setup, strobe and hold. pause_o is high in the first three of these cycles.
- R2: A store to an address with bit 31 clear lasts two cycles: the request cycle, then the strobe cycle. pause_o is high only in the request cycle.
- R3: In a high-region store, the request cycle shows pc_i on mem_addr_o with the data bus released. In the setup cycle, mem_addr_o carries the store address and the write data is driven with mem_we_o low. In the strobe cycle, mem_we_o is high. In the hold cycle, mem_we_o is low again while the address and data are unchanged.
- R4: In a low-region store, the request cycle shows pc_i, and the next cycle drives the store address and data with mem_we_o high.
- R5: In the cycle after the last cycle of any store, mem_addr_o follows pc_i again.
- R6: mem_wdata_oe_o is high, and mem_wdata_o is driven, only in the data-access cycles. In every other cycle mem_wdata_o is high impedance, mem_bsel_o is 0000 and mem_we_o is low.
- R7: st_size_i uses 0 for a byte, 1 for a halfword and 2 for a word. Lane enables are big-endian, with bit 3 of mem_bsel_o as the lane at byte offset 0. A byte at offset k enables bit 3-k only, so offset 11 gives 0001. A halfword at offset 00 gives 1100 and one at offset 10 gives 0011. A word gives 1111.
- R8: pause_o rises in the cycle the store request is accepted and falls in the final cycle of the sequence.
- R9: A request presented with nullify_i high is dropped. It raises no pause, produces no strobe and does not drive the data bus.
- R10: An active-low reset, even in the middle of a sequence, returns the block at once to idle: no strobe, no pause, data bus released, and the address bus following pc_i.
- R11: While a sequence is running, changes on st_req_i, st_addr_i, st_data_i and st_size_i are ignored. The captured address, data and lanes stay on the bus until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Program counter, used as the fetch address when no store is on the bus |
| st_req_i | input | 1 | Store request from the core |
| st_addr_i | input | 32 | Store address |
| st_data_i | input | 32 | Store data, already aligned to its lanes |
| st_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| nullify_i | input | 1 | Drops the store request presented in the same cycle |
| pause_o | output | 1 | Stall to the core |
| mem_addr_o | output | 32 | Memory address bus |
| mem_wdata_o | output | 32 | Write data, high impedance when not driven |
| mem_wdata_oe_o | output | 1 | High when mem_wdata_o is driven |
| mem_bsel_o | output | 4 | Byte-lane enables |
| mem_we_o | output | 1 | Write strobe |

## Verification
The hardest state to reach from the ports is a running high-region sequence in which the core changes the store inputs. A real core is paused at that point and would never do this. The bench does it on purpose: it holds st_req_i high and loads a new address, new data and a new size during setup and strobe, and then checks that the hold cycle still shows the values captured at the start. Reset is also asserted in the setup cycle of a high store, and the bench checks that the bus drops back to fetch at once, without waiting for a clock edge.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETUP  = 2'd1,
    SEQ_STROBE = 2'd2,
    SEQ_HOLD   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } st_size_e;
endpackage

// File: rtl/store_lane_dec.sv
module store_lane_dec #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [LANES-1:0] sel_o
);
  import store_seq_pkg::*;

  localparam logic [OFF_W:0] ONE = (OFF_W+1)'(1);

  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] base;
  logic [OFF_W:0] limit;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes = ONE;
      SZ_HALF: nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(LANES);
    endcase
    // align offset down to access size
    base  = {1'b0, off_i} & ~(nbytes - ONE);
    limit = base + nbytes;
  end

  // big-endian: lane LANES-1 holds byte offset 0
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFF_W:0] POS = (OFF_W+1)'(LANES - 1 - l);
    assign sel_o[l] = (POS >= base) && (POS < limit);
  end
endmodule

// File: rtl/store_seq_fsm.sv
module store_seq_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic nullify_i,
  input  logic high_i,
  output logic accept_o,
  output logic drive_o,
  output logic we_o,
  output logic pause_o
);
  import store_seq_pkg::*;

  seq_state_e state_q, state_d;
  logic       high_q;

  assign accept_o = (state_q == SEQ_IDLE) && req_i && !nullify_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (accept_o) state_d = high_i ? SEQ_SETUP : SEQ_STROBE;
      SEQ_SETUP:  state_d = SEQ_STROBE;
      SEQ_STROBE: state_d = high_q ? SEQ_HOLD : SEQ_IDLE;
      SEQ_HOLD:   state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      high_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) high_q <= high_i;
    end
  end

  assign drive_o = (state_q != SEQ_IDLE);
  assign we_o    = (state_q == SEQ_STROBE);
  // pause drops in the final cycle of the sequence
  assign pause_o = accept_o || (state_q == SEQ_SETUP) ||
                   ((state_q == SEQ_STROBE) && high_q);
endmodule

// File: rtl/store_seq_bus.sv
module store_seq_bus #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              drive_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  sel_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= '0;
    end else if (capture_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
      sel_q  <= sel_i;
    end
  end

  assign addr_o = drive_i ? addr_q : pc_i;
  assign data_o = data_q;
  assign sel_o  = drive_i ? sel_q : '0;
endmodule

// File: rtl/store_seq.sv
module store_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              st_req_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [1:0]        st_size_i,
  input  logic              nullify_i,
  output logic              pause_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output wire  [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wdata_oe_o,
  output logic [DATA_W/8-1:0] mem_bsel_o,
  output logic              mem_we_o
);
  localparam int LANES      = DATA_W / 8;
  localparam int OFF_W      = $clog2(LANES);
  localparam int REGION_BIT = ADDR_W - 1;

  logic [LANES-1:0]  lane_sel;
  logic [DATA_W-1:0] wdata;
  logic              accept;
  logic              drive;

  store_lane_dec #(.LANES(LANES)) u_lane (
    .off_i  (st_addr_i[OFF_W-1:0]),
    .size_i (st_size_i),
    .sel_o  (lane_sel)
  );

  store_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (st_req_i),
    .nullify_i (nullify_i),
    .high_i    (st_addr_i[REGION_BIT]),
    .accept_o  (accept),
    .drive_o   (drive),
    .we_o      (mem_we_o),
    .pause_o   (pause_o)
  );

  store_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .drive_i   (drive),
    .pc_i      (pc_i),
    .addr_i    (st_addr_i),
    .data_i    (st_data_i),
    .sel_i     (lane_sel),
    .addr_o    (mem_addr_o),
    .data_o    (wdata),
    .sel_o     (mem_bsel_o)
  );

  assign mem_wdata_oe_o = drive;
  assign mem_wdata_o    = drive ? wdata : {DATA_W{1'bz}};
endmodule

// File: rtl/store_seq_chk.sv
module store_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                st_req_i,
  input logic                nullify_i,
  input logic                pause_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic                mem_wdata_oe_o,
  input logic [DATA_W/8-1:0] mem_bsel_o,
  input logic                mem_we_o
);
  // R6
  released_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wdata_oe_o |-> (mem_bsel_o == '0) && !mem_we_o);

  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R1
  high_strobe_paused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_addr_o[ADDR_W-1] |-> pause_o);

  // R2
  low_strobe_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_addr_o[ADDR_W-1] |-> !pause_o);

  // R3
  high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_addr_o[ADDR_W-1] |=>
      mem_wdata_oe_o && $stable(mem_addr_o) && !pause_o && !mem_we_o);

  // R9
  nullify_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_i && nullify_i && !mem_wdata_oe_o |-> !pause_o);

  // R9
  nullify_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_i && nullify_i && !mem_wdata_oe_o |=> !mem_we_o);

  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !mem_we_o && !mem_wdata_oe_o && (mem_bsel_o == '0));
endmodule

bind store_seq store_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .st_req_i       (st_req_i),
  .nullify_i      (nullify_i),
  .pause_o        (pause_o),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_oe_o (mem_wdata_oe_o),
  .mem_bsel_o     (mem_bsel_o),
  .mem_we_o       (mem_we_o)
);

// File: tb/store_seq_test.sv
module store_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = 32'h0000_0100;
  logic        st_req_i = 1'b0;
  logic [31:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic [1:0]  st_size_i = 2'd2;
  logic        nullify_i = 1'b0;
  logic        pause_o;
  logic [31:0] mem_addr_o;
  wire  [31:0] mem_wdata_o;
  logic        mem_wdata_oe_o;
  logic [3:0]  mem_bsel_o;
  logic        mem_we_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  bsel;
    logic        oe;
    logic        we;
    logic        pause;
    string       tag;
  } exp_t;

  exp_t q[$];

  store_seq uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: one expected item per cycle, sampled mid-cycle
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(mem_addr_o === it.addr, it.tag, "addr", mem_addr_o, it.addr);
      chk(mem_wdata_oe_o === it.oe, {it.tag, "/R6"}, "oe",
          32'(mem_wdata_oe_o), 32'(it.oe));
      chk(mem_bsel_o === it.bsel, {it.tag, "/R7"}, "bsel",
          32'(mem_bsel_o), 32'(it.bsel));
      chk(mem_we_o === it.we, it.tag, "we", 32'(mem_we_o), 32'(it.we));
      chk(pause_o === it.pause, {it.tag, "/R8"}, "pause",
          32'(pause_o), 32'(it.pause));
      if (it.oe)
        chk(mem_wdata_o === it.data, it.tag, "wdata", mem_wdata_o, it.data);
    end
  end

  function automatic logic [3:0] lanes(input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b1000 >> a[1:0];
      2'd1:    return a[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b,
                      input logic oe, input logic we, input logic p, input string tag);
    exp_t it;
    it.addr = a; it.data = d; it.bsel = b; it.oe = oe; it.we = we; it.pause = p;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // driver: presents a store and queues the expected bus cycles
  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                       input logic nul, input bit poke);
    logic [3:0] b;
    b = lanes(a, sz);
    st_req_i = 1'b1; st_addr_i = a; st_data_i = d; st_size_i = sz; nullify_i = nul;
    push(pc_i, d, 4'b0, 1'b0, 1'b0, !nul, nul ? "R9" : "R3/R4");
    step();
    nullify_i = 1'b0;
    if (poke) begin  // R11: core inputs move mid-sequence
      st_req_i = 1'b1; st_addr_i = ~a; st_data_i = ~d; st_size_i = 2'd0;
    end else begin
      st_req_i = 1'b0;
    end
    if (!nul) begin
      if (a[31]) begin
        push(a, d, b, 1'b1, 1'b0, 1'b1, poke ? "R11" : "R1/R3");
        step();
        push(a, d, b, 1'b1, 1'b1, 1'b1, poke ? "R11" : "R1/R3");
        step();
        st_req_i = 1'b0;
        push(a, d, b, 1'b1, 1'b0, 1'b0, poke ? "R11" : "R1/R3");
        step();
      end else begin
        st_req_i = 1'b0;
        push(a, d, b, 1'b1, 1'b1, 1'b0, poke ? "R11" : "R2/R4");
        step();
      end
    end
    st_req_i = 1'b0;
    push(pc_i, d, 4'b0, 1'b0, 1'b0, 1'b0, "R5/R6");
    step();
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    // R10: state during reset
    chk(!mem_we_o && !mem_wdata_oe_o && !pause_o && mem_bsel_o == 4'b0, "R10",
        "reset idle", {mem_we_o, mem_wdata_oe_o, pause_o, mem_bsel_o}, 32'h0);
    chk(mem_addr_o === pc_i, "R10", "reset addr", mem_addr_o, pc_i);
    repeat (2) step();
    rst_ni = 1'b1;
    step();

    store(32'h8000_0010, 32'hCAFE_0001, 2'd2, 1'b0, 1'b0);   // R1 high word
    pc_i = 32'h0000_0104;
    store(32'h0000_0020, 32'h1234_5678, 2'd2, 1'b0, 1'b0);   // R2 low word
    pc_i = 32'h0000_0108;
    store(32'hFFFF_FFFF, 32'h3131_3131, 2'd0, 1'b0, 1'b0);   // R7 byte offset 3
    for (int k = 0; k < 4; k++) begin                        // R7 byte lanes
      pc_i = 32'h0000_0200 + 32'(k * 4);
      store(32'h0000_0040 + 32'(k), 32'h0101_0101 * 32'(k + 1), 2'd0, 1'b0, 1'b0);
    end
    store(32'h8000_0102, 32'hAAAA_5555, 2'd1, 1'b0, 1'b0);   // R7 half offset 2
    store(32'h0000_0100, 32'h5555_AAAA, 2'd1, 1'b0, 1'b0);   // R7 half offset 0
    pc_i = 32'h0000_0300;
    store(32'h8000_0200, 32'hDEAD_BEEF, 2'd2, 1'b1, 1'b0);   // R9 high dropped
    store(32'h0000_0200, 32'hDEAD_BEEF, 2'd2, 1'b1, 1'b0);   // R9 low dropped
    pc_i = 32'h0000_0310;
    store(32'h8000_0300, 32'h0BAD_F00D, 2'd2, 1'b0, 1'b1);   // R11 high
    store(32'h0000_0300, 32'h0BAD_F00D, 2'd1, 1'b0, 1'b1);   // R11 low
    store(32'h0000_0004, 32'h7777_0000, 2'd2, 1'b0, 1'b0);   // back-to-back R2
    store(32'h8000_0004, 32'h8888_0000, 2'd2, 1'b0, 1'b0);   // back-to-back R1

    // R10: reset in the setup cycle of a high store
    st_req_i = 1'b1; st_addr_i = 32'h8000_0400; st_data_i = 32'h4444_4444;
    st_size_i = 2'd2;
    step();
    st_req_i = 1'b0;
    #0.5;
    chk(mem_wdata_oe_o === 1'b1 && pause_o === 1'b1, "R10", "setup before reset",
        {30'b0, mem_wdata_oe_o, pause_o}, 32'h3);
    rst_ni = 1'b0;
    #0.5;
    chk(!mem_we_o && !mem_wdata_oe_o && !pause_o && mem_bsel_o == 4'b0, "R10",
        "mid-sequence reset", {mem_we_o, mem_wdata_oe_o, pause_o, mem_bsel_o}, 32'h0);
    chk(mem_addr_o === pc_i, "R10", "mid-sequence reset addr", mem_addr_o, pc_i);
    step();
    rst_ni = 1'b1;
    step();
    chk(!mem_we_o && !mem_wdata_oe_o && !pause_o, "R10", "after reset release",
        {mem_we_o, mem_wdata_oe_o, pause_o}, 32'h0);
    store(32'h0000_0500, 32'h5050_5050, 2'd2, 1'b0, 1'b0);   // recovers, R2

    repeat (2) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule